// File: doc/BRIEF.md
# Synchronized Wiper Stepping Controller

This block produces two 7-bit tap codes for a pair of resistor-ladder selectors that move together. The main tap swings around a programmed base wiper value. The mirror tap swings by the same offset around the fixed centre code 64. The swing is a bounded triangle: the offset climbs from zero to +N, falls to -N, and then repeats. It moves one step after a programmable number of pulses on an external, asynchronous sync input.

A step-control byte sets the swing half-width N and the prescale period. The base value is pulled inward so that the main tap never leaves 0..127. After reset, and after every re-initialise pulse, the block sits through a warm-up window counted in sync pulses. During that window it shows the plain wiper value and the centre code. The surrounding logic raises the re-initialise pulse whenever the wiper or step-control value is rewritten.

Top module: `wiper_stepper`

## Requirements
- R1: After reset or a one-cycle-or-longer `reinit` pulse, `tap_main` equals `wiper` unchanged, `tap_mirror` equals 64, and the offset restarts from zero.
- R2: Stepping stays disabled until 512 + P/2 falling sync edges have been counted since reset or `reinit`, where P is the selected period. During that window the outputs stay as in R1.
- R3: `step_ctrl[6:5]` selects P: 00 → 32, 01 → 64, 10 → 128, 11 → 256 falling sync edges per offset step. `step_ctrl[7]` has no effect on either output.
- R4: Only a falling edge of `sync_in` advances the block. A rising edge alone leaves both outputs unchanged.
- R5: After warm-up, the offset starts at 0 and moves up first by one per P edges. It saturates at +N and then reverses, and it saturates at -N and then reverses, where N = `step_ctrl[4:0]`. The mirror output never moves by more than one code per clock.
- R6: After warm-up, `tap_main` = clamp(`wiper`, N, 127-N) + offset. For example, wiper 16 with N = 31 shows 31 right after warm-up.
- R7: `tap_mirror` = 64 + offset at all times, so |`tap_mirror` - 64| never exceeds N.
- R8: With N = 0, `tap_main` equals `wiper` and `tap_mirror` equals 64 for any number of sync pulses.
- R9: With wiper 65 and N = 16, `tap_main` sweeps 49..81 and `tap_mirror` sweeps 48..80. With wiper 16 and N = 31, they sweep 0..62 and 33..95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | Asynchronous stepping pulse input; the falling edge counts |
| wiper | input | 7 | Base wiper code |
| step_ctrl | input | 8 | [4:0] half-width N, [6:5] period select, [7] unused |
| reinit | input | 1 | Restart warm-up and stepping state |
| tap_main | output | 7 | Stepped tap code around the clamped wiper |
| tap_mirror | output | 7 | Stepped tap code around 64 |

## Verification
The bench builds the block with its default parameters: a 7-bit code, a 5-bit half-width, a two-bit period select starting at 32 pulses, and a 512-pulse warm-up base. With these values every period choice and the full 31-step swing fit in a short run. The warm-up boundary can be observed at the exact pulse for both the shortest and the longest period. Complete triangles at both rails expose the clamp and the saturation turn-arounds. Randomized configurations, including the unused bit set, are compared pulse by pulse against a bench model.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;
endpackage

// File: rtl/wstep_sync_fall.sv
module wstep_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_in;
        else chain_q[g] <= chain_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/wstep_seq.sv
module wstep_seq #(
  parameter int PSEL_W       = 2,
  parameter int PER_LOG2_MIN = 5,
  parameter int WARM_BASE    = 512,
  parameter int PCNT_W       = 9,
  parameter int WARM_W       = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit,
  input  logic              fall,
  input  logic [PSEL_W-1:0] psel,
  input  logic              sc_zero,
  output logic              run,
  output logic              step
);
  logic [PCNT_W-1:0] period;
  logic [WARM_W-1:0] warm_lim;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [PCNT_W-1:0] pcnt_q, pcnt_d;

  always_comb begin
    period   = {{(PCNT_W-1){1'b0}}, 1'b1} << (PER_LOG2_MIN + int'(psel));
    warm_lim = WARM_W'(WARM_BASE) + WARM_W'(period >> 1);
    run      = (warm_q >= warm_lim);
    step     = fall && run && !sc_zero && (pcnt_q == PCNT_W'(1));
  end

  always_comb begin
    warm_d = warm_q;
    pcnt_d = pcnt_q;
    if (reinit) begin
      warm_d = '0;
      pcnt_d = period;
    end else if (!run) begin
      pcnt_d = period;
      if (fall) warm_d = warm_q + WARM_W'(1);
    end else if (fall && !sc_zero) begin
      if (pcnt_q == PCNT_W'(1)) pcnt_d = period;
      else                      pcnt_d = pcnt_q - PCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      pcnt_q <= '0;
    end else begin
      warm_q <= warm_d;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/wstep_tri.sv
module wstep_tri #(
  parameter int SC_W  = 5,
  parameter int OFF_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    step,
  input  logic [SC_W-1:0]         sc,
  output logic signed [OFF_W-1:0] off
);
  import wstep_pkg::*;

  logic signed [OFF_W-1:0] off_q, off_d;
  logic signed [OFF_W:0]   nxt, lim;
  dir_e                    dir_q, dir_d;

  always_comb begin
    off_d = off_q;
    dir_d = dir_q;
    lim   = $signed({2'b00, sc});
    nxt   = {off_q[OFF_W-1], off_q};
    if (clear) begin
      off_d = '0;
      dir_d = DIR_UP;
    end else if (step) begin
      if (dir_q == DIR_UP) begin
        nxt = nxt + 1'sb1 - 1'sb1 + (OFF_W+1)'(1);
        if (nxt >= lim) begin
          nxt   = lim;
          dir_d = DIR_DN;
        end
      end else begin
        nxt = nxt - (OFF_W+1)'(1);
        if (nxt <= -lim) begin
          nxt   = -lim;
          dir_d = DIR_UP;
        end
      end
      off_d = nxt[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      off_q <= off_d;
      dir_q <= dir_d;
    end
  end

  assign off = off_q;
endmodule

// File: rtl/wstep_map.sv
module wstep_map #(
  parameter int CODE_W = 7,
  parameter int SC_W   = 5,
  parameter int OFF_W  = 6,
  parameter int CENTER = 64
) (
  input  logic                    run,
  input  logic [CODE_W-1:0]       wiper,
  input  logic [SC_W-1:0]         sc,
  input  logic signed [OFF_W-1:0] off,
  output logic [CODE_W-1:0]       tap_main,
  output logic [CODE_W-1:0]       tap_mirror
);
  localparam int TOP = (1 << CODE_W) - 1;

  logic [CODE_W-1:0]        lo, hi, base;
  logic signed [CODE_W+1:0] off_x, sum_main, sum_mir;

  always_comb begin
    lo       = CODE_W'(sc);
    hi       = CODE_W'(TOP) - CODE_W'(sc);
    base     = (wiper < lo) ? lo : ((wiper > hi) ? hi : wiper);
    off_x    = {{(CODE_W+2-OFF_W){off[OFF_W-1]}}, off};
    sum_main = $signed({2'b00, base}) + off_x;
    sum_mir  = $signed((CODE_W+2)'(CENTER)) + off_x;
    if (run) begin
      tap_main   = sum_main[CODE_W-1:0];
      tap_mirror = sum_mir[CODE_W-1:0];
    end else begin
      tap_main   = wiper;
      tap_mirror = CODE_W'(CENTER);
    end
  end
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
  parameter int CODE_W       = 7,
  parameter int SC_W         = 5,
  parameter int PSEL_W       = 2,
  parameter int PER_LOG2_MIN = 5,
  parameter int WARM_BASE    = 512,
  parameter int CENTER       = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_in,
  input  logic [CODE_W-1:0]        wiper,
  input  logic [SC_W+PSEL_W:0]     step_ctrl,
  input  logic                     reinit,
  output logic [CODE_W-1:0]        tap_main,
  output logic [CODE_W-1:0]        tap_mirror
);
  localparam int OFF_W   = SC_W + 1;
  localparam int PCNT_W  = PER_LOG2_MIN + (1 << PSEL_W);
  localparam int MAX_PER = 1 << (PER_LOG2_MIN + (1 << PSEL_W) - 1);
  localparam int WARM_W  = $clog2(WARM_BASE + MAX_PER / 2 + 1);

  logic                    rst_meta, rst_core;
  logic                    fall, run, step;
  logic [SC_W-1:0]         sc;
  logic [PSEL_W-1:0]       psel;
  logic signed [OFF_W-1:0] off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  assign sc   = step_ctrl[SC_W-1:0];
  assign psel = step_ctrl[SC_W+PSEL_W-1:SC_W];

  wstep_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core), .async_in(sync_in), .fall(fall)
  );

  wstep_seq #(
    .PSEL_W(PSEL_W), .PER_LOG2_MIN(PER_LOG2_MIN), .WARM_BASE(WARM_BASE),
    .PCNT_W(PCNT_W), .WARM_W(WARM_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_core), .reinit(reinit), .fall(fall),
    .psel(psel), .sc_zero(sc == '0), .run(run), .step(step)
  );

  wstep_tri #(.SC_W(SC_W), .OFF_W(OFF_W)) u_tri (
    .clk(clk), .rst_n(rst_core), .clear(reinit || !run), .step(step),
    .sc(sc), .off(off)
  );

  wstep_map #(.CODE_W(CODE_W), .SC_W(SC_W), .OFF_W(OFF_W), .CENTER(CENTER)) u_map (
    .run(run), .wiper(wiper), .sc(sc), .off(off),
    .tap_main(tap_main), .tap_mirror(tap_mirror)
  );
endmodule

// File: rtl/wiper_stepper_chk.sv
module wiper_stepper_chk #(
  parameter int CODE_W = 7,
  parameter int SC_W   = 5,
  parameter int PSEL_W = 2,
  parameter int CENTER = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CODE_W-1:0]    wiper,
  input logic [SC_W+PSEL_W:0] step_ctrl,
  input logic                 reinit,
  input logic [CODE_W-1:0]    tap_main,
  input logic [CODE_W-1:0]    tap_mirror
);
  logic [SC_W-1:0] sc_c;
  int              dmir, prev_mir;
  assign sc_c = step_ctrl[SC_W-1:0];
  assign dmir = int'(tap_mirror) - CENTER;

  // R1
  reinit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (tap_mirror == CODE_W'(CENTER)) && (tap_main == wiper));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    1'b1 |=> ((int'(tap_mirror) - int'($past(tap_mirror))) <= 1) &&
             ((int'(tap_mirror) - int'($past(tap_mirror))) >= -1));

  // R7
  mirror_bound_chk: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    (dmir <= int'(sc_c)) && (dmir >= -int'(sc_c)));

  // R8
  zero_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    (sc_c == '0) |-> (tap_main == wiper) && (tap_mirror == CODE_W'(CENTER)));
endmodule

bind wiper_stepper wiper_stepper_chk #(
  .CODE_W(CODE_W), .SC_W(SC_W), .PSEL_W(PSEL_W), .CENTER(CENTER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wiper(wiper), .step_ctrl(step_ctrl),
  .reinit(reinit), .tap_main(tap_main), .tap_mirror(tap_mirror)
);

// File: tb/wiper_stepper_tb.sv
module wiper_stepper_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_in;
  logic [6:0] wiper;
  logic [7:0] step_ctrl;
  logic       reinit;
  logic [6:0] tap_main, tap_mirror;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int m_warm, m_pc, m_off, m_up;
  int mn_main, mx_main, mn_mir, mx_mir;

  always #5 clk = ~clk;

  wiper_stepper u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .wiper(wiper),
    .step_ctrl(step_ctrl), .reinit(reinit), .tap_main(tap_main), .tap_mirror(tap_mirror)
  );

  function automatic int f_sc();   return int'(step_ctrl[4:0]); endfunction
  function automatic int f_per();  return 32 << int'(step_ctrl[6:5]); endfunction
  function automatic int f_lim();  return 512 + f_per() / 2; endfunction
  function automatic int f_base();
    int lo = f_sc();
    int hi = 127 - f_sc();
    int w  = int'(wiper);
    return (w < lo) ? lo : ((w > hi) ? hi : w);
  endfunction
  function automatic int exp_main();
    return (m_warm < f_lim()) ? int'(wiper) : f_base() + m_off;
  endfunction
  function automatic int exp_mir();
    return (m_warm < f_lim()) ? 64 : 64 + m_off;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string tag);
    check({tag, " main"}, int'(tap_main), exp_main());
    check({tag, " mirror"}, int'(tap_mirror), exp_mir());
  endtask

  task automatic model_fall();
    if (m_warm < f_lim()) begin
      m_warm++;
      m_pc = f_per();
    end else if (f_sc() != 0) begin
      if (m_pc == 1) begin
        m_pc = f_per();
        if (m_up != 0) begin
          m_off++;
          if (m_off >= f_sc()) begin m_off = f_sc(); m_up = 0; end
        end else begin
          m_off--;
          if (m_off <= -f_sc()) begin m_off = -f_sc(); m_up = 1; end
        end
      end else m_pc--;
    end
  endtask

  // one sync pulse; checks after the rise (R4) and after the fall
  task automatic pulse(input string tag);
    @(negedge clk) sync_in = 1'b1;
    repeat (4) @(negedge clk);
    check({tag, " R4 rise-only"}, int'(tap_mirror), exp_mir());
    sync_in = 1'b0;
    repeat (4) @(negedge clk);
    model_fall();
    check_outs(tag);
    if (m_warm >= f_lim()) begin
      if (int'(tap_main) < mn_main) mn_main = int'(tap_main);
      if (int'(tap_main) > mx_main) mx_main = int'(tap_main);
      if (int'(tap_mirror) < mn_mir) mn_mir = int'(tap_mirror);
      if (int'(tap_mirror) > mx_mir) mx_mir = int'(tap_mirror);
    end
  endtask

  task automatic configure(input int w, input int sc, input int ps, input int rsv);
    @(negedge clk) reinit = 1'b1;
    @(negedge clk);
    wiper     = 7'(w);
    step_ctrl = {1'(rsv), 2'(ps), 5'(sc)};
    @(negedge clk) reinit = 1'b0;
    m_warm = 0; m_off = 0; m_up = 1; m_pc = f_per();
    mn_main = 999; mx_main = -1; mn_mir = 999; mx_mir = -1;
    @(negedge clk);
    check_outs("R1 after reinit");
  endtask

  initial begin
    rst_n = 1'b0; sync_in = 1'b0; reinit = 1'b0;
    wiper = 7'd65; step_ctrl = 8'h10;
    m_warm = 0; m_off = 0; m_up = 1; m_pc = 32;
    mn_main = 999; mx_main = -1; mn_mir = 999; mx_mir = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_outs("R1 reset");

    // R9 example 1 with R2 boundary (period 32, window 528)
    for (int i = 0; i < 527; i++) pulse("R2 warm");
    check("R2 last warm main", int'(tap_main), 65);
    pulse("R2 window end");
    check("R2 R6 window end main", int'(tap_main), 65);
    for (int i = 0; i < 31; i++) pulse("R3 R5 period32");
    check("R5 no step before period", int'(tap_mirror), 64);
    pulse("R5 first step");
    check("R5 first step up", int'(tap_mirror), 65);
    for (int i = 0; i < 64 * 32; i++) pulse("R5 R7 sweep1");
    check("R9 ex1 main min", mn_main, 49);
    check("R9 ex1 main max", mx_main, 81);
    check("R9 ex1 mirror min", mn_mir, 48);
    check("R9 ex1 mirror max", mx_mir, 80);

    // R9 example 3: lower rail clamp
    configure(16, 31, 0, 0);
    for (int i = 0; i < 528; i++) pulse("R2 warm2");
    check("R6 clamp after warm-up", int'(tap_main), 31);
    for (int i = 0; i < 124 * 32 + 32; i++) pulse("R5 R6 sweep2");
    check("R9 ex3 main min", mn_main, 0);
    check("R9 ex3 main max", mx_main, 62);
    check("R9 ex3 mirror min", mn_mir, 33);
    check("R9 ex3 mirror max", mx_mir, 95);

    // R3 longest period: window 640, step every 256
    configure(112, 3, 3, 0);
    for (int i = 0; i < 640; i++) pulse("R2 warm256");
    check("R2 window 640 main", int'(tap_main), 112);
    for (int i = 0; i < 255; i++) pulse("R3 period256");
    check("R3 no step at 255", int'(tap_mirror), 64);
    pulse("R3 step at 256");
    check("R3 step at 256", int'(tap_mirror), 65);

    // R8 stepping disabled
    configure(100, 0, 0, 0);
    for (int i = 0; i < 700; i++) pulse("R8 zero count");
    check("R8 main holds wiper", int'(tap_main), 100);
    check("R8 mirror holds 64", int'(tap_mirror), 64);

    // R1 reinit mid-sweep
    configure(40, 5, 0, 0);
    for (int i = 0; i < 600; i++) pulse("R5 pre-reinit");
    configure(40, 5, 0, 0);
    check("R1 reinit main", int'(tap_main), 40);
    check("R1 reinit mirror", int'(tap_mirror), 64);

    // random configurations, some with the unused bit set (R3)
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < 4; k++) begin
      int ps = (k == 3) ? 1 : int'($urandom_range(0, 2));
      configure(int'($urandom_range(0, 127)), int'($urandom_range(1, 31)), ps, k % 2);
      for (int i = 0; i < f_lim() + 300; i++) pulse("R3 R5 R6 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule